// File: doc/BRIEF.md
# Stack Machine Arithmetic Unit With Carry

This block computes one step of arithmetic for a stack machine that keeps its two top entries (top and next) in registers. Each valid cycle it takes the current top, next, the entry below next, the carry flag, a 3-bit operation code and a 2-bit stack action. One clock later it presents the new top, new next, the carry and overflow flags, and a single-cycle request to pop or push the stack memory beneath next.

A binary operation either consumes its operands (pop action: the result replaces both, and the entry below moves up into next) or keeps them (push action: the result lands on top, old top moves to next, old next is pushed down). With the both action the code selects a unary operation that rewrites top in place. Several of these shift bits through the carry. The none action swaps top and next.

Top module: `sp_alu`

## Requirements
- R1: While rst_ni is low, tos_o, nos_o, carry_o, ovfl_o, push_o, pop_o and push_data_o are all zero.
- R2: Under pop (act 1) or push (act 2), codes 0..3 give ADD nos+tos, ADC nos+tos+carry_i, SUB nos-tos and SSUB tos-nos, modulo 2^WIDTH, on tos_o one cycle after valid_i.
- R3: For codes 0..3, carry_o is the adder carry out; for SUB and SSUB this is 1 exactly when no borrow occurs.
- R4: For codes 0..3, ovfl_o is 1 on two's-complement signed overflow. Any other valid operation clears ovfl_o.
- R5: Under pop or push, codes 4..7 give AND, OR, XOR, and next passed through, and carry_o takes carry_i.
- R6: Pop (act 1) sets nos_o to below_i and pulses pop_o for one cycle.
- R7: Push (act 2) sets nos_o to the old tos_i and push_data_o to the old nos_i, and pulses push_o for one cycle.
- R8: Under both (act 3), code 1 shifts left with 0 into the LSB and the MSB into carry. Code 2 shifts right keeping the MSB. Code 3 shifts right with 0 into the MSB. In codes 2 and 3 the LSB goes to carry.
- R9: Under both, code 4 rotates right through carry and code 5 rotates left through carry.
- R10: Under both, code 0 inverts top, code 6 gives all ones when top is zero and zero otherwise, and code 7 inverts the carry and leaves top unchanged. Codes 0 and 6 keep carry_i. Every both operation leaves nos_o equal to nos_i.
- R11: None (act 0) swaps top and next and keeps carry_i, whatever the code.
- R12: With valid_i low, tos_o, nos_o, carry_o and ovfl_o hold and push_o and pop_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Execute this cycle |
| op_i | input | 3 | Operation code |
| act_i | input | 2 | Stack action: 0 none, 1 pop, 2 push, 3 both |
| tos_i | input | WIDTH | Current top |
| nos_i | input | WIDTH | Current next |
| below_i | input | WIDTH | Stack entry below next |
| carry_i | input | 1 | Current carry |
| tos_o | output | WIDTH | New top |
| nos_o | output | WIDTH | New next |
| carry_o | output | 1 | New carry |
| ovfl_o | output | 1 | Signed overflow flag |
| push_o | output | 1 | Push request for push_data_o |
| pop_o | output | 1 | Pop request, below entry consumed |
| push_data_o | output | WIDTH | Value to push |

## Verification
The assertions assume that below_i, carry_i and the operands are stable and known during every valid cycle. They also assume that every act and op value is legal, which holds because both fields are fully decoded. The stimulus drives all inputs on the falling edge from $urandom with a fixed seed and covers every act/op pair. Directed cases add the sign-boundary operands 0, all-ones, the most negative and the most positive values, and idle cycles between operations.

// File: rtl/sp_alu_pkg.sv
package sp_alu_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_POP  = 2'd1,
    ACT_PUSH = 2'd2,
    ACT_BOTH = 2'd3
  } act_e;

  typedef enum logic [2:0] {
    BIN_ADD  = 3'd0,
    BIN_ADC  = 3'd1,
    BIN_SUB  = 3'd2,
    BIN_SSUB = 3'd3,
    BIN_AND  = 3'd4,
    BIN_OR   = 3'd5,
    BIN_XOR  = 3'd6,
    BIN_PASS = 3'd7
  } bin_e;

  typedef enum logic [2:0] {
    UN_NOT  = 3'd0,
    UN_SL   = 3'd1,
    UN_ASR  = 3'd2,
    UN_LSR  = 3'd3,
    UN_ROR  = 3'd4,
    UN_ROL  = 3'd5,
    UN_ZEQU = 3'd6,
    UN_CC   = 3'd7
  } un_e;
endpackage

// File: rtl/sp_alu_bin.sv
module sp_alu_bin
  import sp_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] nos_i,
  input  logic [WIDTH-1:0] tos_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o,
  output logic             ovfl_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] opa, opb;
  logic             cin, arith;
  logic [WIDTH:0]   sum;

  // one adder: subtraction as a + ~b + 1
  always_comb begin
    opa   = nos_i;
    opb   = tos_i;
    cin   = 1'b0;
    arith = 1'b1;
    unique case (bin_e'(op_i))
      BIN_ADD:  ;
      BIN_ADC:  cin = carry_i;
      BIN_SUB:  begin opb = ~tos_i; cin = 1'b1; end
      BIN_SSUB: begin opa = tos_i; opb = ~nos_i; cin = 1'b1; end
      default:  arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    unique case (bin_e'(op_i))
      BIN_AND:  res_o = nos_i & tos_i;
      BIN_OR:   res_o = nos_i | tos_i;
      BIN_XOR:  res_o = nos_i ^ tos_i;
      BIN_PASS: res_o = nos_i;
      default:  res_o = sum[MSB:0];
    endcase
    carry_o = arith ? sum[WIDTH] : carry_i;
    ovfl_o  = arith & (opa[MSB] == opb[MSB]) & (sum[MSB] != opa[MSB]);
  end
endmodule

// File: rtl/sp_alu_una.sv
module sp_alu_una
  import sp_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] tos_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    res_o   = tos_i;
    carry_o = carry_i;
    unique case (un_e'(op_i))
      UN_NOT:  res_o = ~tos_i;
      UN_SL:   begin res_o = {tos_i[MSB-1:0], 1'b0};     carry_o = tos_i[MSB]; end
      UN_ASR:  begin res_o = {tos_i[MSB], tos_i[MSB:1]}; carry_o = tos_i[0];   end
      UN_LSR:  begin res_o = {1'b0, tos_i[MSB:1]};       carry_o = tos_i[0];   end
      UN_ROR:  begin res_o = {carry_i, tos_i[MSB:1]};    carry_o = tos_i[0];   end
      UN_ROL:  begin res_o = {tos_i[MSB-1:0], carry_i};  carry_o = tos_i[MSB]; end
      UN_ZEQU: res_o = {WIDTH{tos_i == '0}};
      UN_CC:   carry_o = ~carry_i;
    endcase
  end
endmodule

// File: rtl/sp_alu.sv
module sp_alu
  import sp_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic [1:0]       act_i,
  input  logic [WIDTH-1:0] tos_i,
  input  logic [WIDTH-1:0] nos_i,
  input  logic [WIDTH-1:0] below_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] tos_o,
  output logic [WIDTH-1:0] nos_o,
  output logic             carry_o,
  output logic             ovfl_o,
  output logic             push_o,
  output logic             pop_o,
  output logic [WIDTH-1:0] push_data_o
);
  logic [WIDTH-1:0] bin_res, un_res;
  logic             bin_c, bin_v, un_c;
  logic [WIDTH-1:0] tos_d, nos_d;
  logic             c_d, v_d;

  sp_alu_bin #(.WIDTH(WIDTH)) u_bin (
    .op_i, .nos_i, .tos_i, .carry_i,
    .res_o(bin_res), .carry_o(bin_c), .ovfl_o(bin_v)
  );

  sp_alu_una #(.WIDTH(WIDTH)) u_una (
    .op_i, .tos_i, .carry_i,
    .res_o(un_res), .carry_o(un_c)
  );

  always_comb begin
    unique case (act_e'(act_i))
      ACT_NONE: begin tos_d = nos_i;   nos_d = tos_i;   c_d = carry_i; v_d = 1'b0;  end
      ACT_POP:  begin tos_d = bin_res; nos_d = below_i; c_d = bin_c;   v_d = bin_v; end
      ACT_PUSH: begin tos_d = bin_res; nos_d = tos_i;   c_d = bin_c;   v_d = bin_v; end
      default:  begin tos_d = un_res;  nos_d = nos_i;   c_d = un_c;    v_d = 1'b0;  end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tos_o       <= '0;
      nos_o       <= '0;
      carry_o     <= 1'b0;
      ovfl_o      <= 1'b0;
      push_o      <= 1'b0;
      pop_o       <= 1'b0;
      push_data_o <= '0;
    end else begin
      push_o <= valid_i && act_i == ACT_PUSH;
      pop_o  <= valid_i && act_i == ACT_POP;
      if (valid_i) begin
        tos_o   <= tos_d;
        nos_o   <= nos_d;
        carry_o <= c_d;
        ovfl_o  <= v_d;
        if (act_i == ACT_PUSH) push_data_o <= nos_i;
      end
    end
  end

  AST_POP_REFILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && act_i == ACT_POP |=> pop_o && nos_o == $past(below_i)); // R6
  AST_PUSH_SPILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && act_i == ACT_PUSH |=> push_o && nos_o == $past(tos_i) && push_data_o == $past(nos_i)); // R7
  AST_ONE_REQUEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_o && pop_o)); // R12
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(tos_o) && $stable(nos_o) && $stable(carry_o) && !push_o && !pop_o); // R12
  AST_LOGIC_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (act_i == ACT_POP || act_i == ACT_PUSH) && op_i[2] |=> carry_o == $past(carry_i) && !ovfl_o); // R5
  AST_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && act_i == ACT_NONE |=> tos_o == $past(nos_i) && nos_o == $past(tos_i)); // R11
  AST_UNARY_NOS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && act_i == ACT_BOTH |=> nos_o == $past(nos_i) && !ovfl_o); // R10
endmodule

// File: tb/sp_alu_tb.sv
module sp_alu_tb;
  localparam int W = 16;
  localparam int M = W - 1;

  logic clk = 0, rst_ni = 0;
  logic valid;
  logic [2:0] op;
  logic [1:0] act;
  logic [W-1:0] tos, nos, below;
  logic cin;
  logic [W-1:0] tos_o, nos_o, pdata_o;
  logic carry_o, ovfl_o, push_o, pop_o;

  int total = 0, bad = 0;
  logic [W-1:0] e_tos = 0, e_nos = 0, e_pd = 0;
  logic e_c = 0, e_v = 0, e_push = 0, e_pop = 0;

  always #2 clk = ~clk;

  sp_alu #(.WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni, .valid_i(valid), .op_i(op), .act_i(act),
    .tos_i(tos), .nos_i(nos), .below_i(below), .carry_i(cin),
    .tos_o, .nos_o, .carry_o, .ovfl_o, .push_o, .pop_o, .push_data_o(pdata_o)
  );

  function automatic string tag(logic v, logic [1:0] a, logic [2:0] o);
    if (!v) return "R12";
    case (a)
      2'd0: return "R11";
      2'd3: return (o inside {1, 2, 3}) ? "R8" : (o inside {4, 5}) ? "R9" : "R10";
      default: return (o < 4) ? "R2/R3/R4" : "R5";
    endcase
  endfunction

  task automatic model(logic v, logic [2:0] o, logic [1:0] a,
                       logic [W-1:0] t, logic [W-1:0] n, logic [W-1:0] b, logic c);
    logic [W:0] s;
    logic [W-1:0] r;
    logic rc, rv;
    e_push = v && a == 2;
    e_pop  = v && a == 1;
    if (!v) return;
    rc = c; rv = 0; r = t;
    if (a == 0) begin
      e_tos = n; e_nos = t; e_c = c; e_v = 0; return;
    end
    if (a == 3) begin
      case (o)
        0: r = ~t;
        1: begin r = t << 1; rc = t[M]; end
        2: begin r = {t[M], t[M:1]}; rc = t[0]; end
        3: begin r = t >> 1; rc = t[0]; end
        4: begin r = {c, t[M:1]}; rc = t[0]; end
        5: begin r = {t[M-1:0], c}; rc = t[M]; end
        6: r = (t == 0) ? '1 : '0;
        default: rc = ~c;
      endcase
      e_tos = r; e_nos = n; e_c = rc; e_v = 0; return;
    end
    case (o)
      0: begin s = n + t; rv = (n[M] == t[M]) && (s[M] != n[M]); end
      1: begin s = n + t + c; rv = (n[M] == t[M]) && (s[M] != n[M]); end
      2: begin s = {1'b0, n} - {1'b0, t}; s[W] = (n >= t); rv = (n[M] != t[M]) && (s[M] != n[M]); end
      3: begin s = {1'b0, t} - {1'b0, n}; s[W] = (t >= n); rv = (n[M] != t[M]) && (s[M] != t[M]); end
      4: s = {c, n & t};
      5: s = {c, n | t};
      6: s = {c, n ^ t};
      default: s = {c, n};
    endcase
    e_tos = s[M:0]; e_c = s[W]; e_v = rv;
    e_nos = (a == 1) ? b : t;
    if (a == 2) e_pd = n;
  endtask

  task automatic check(string r);
    total++;
    if ({tos_o, nos_o, carry_o, ovfl_o, push_o, pop_o, pdata_o} !==
        {e_tos, e_nos, e_c, e_v, e_push, e_pop, e_pd}) begin
      bad++;
      $display("FAIL %s act=%0d op=%0d got tos=%h nos=%h c=%b v=%b pu=%b po=%b pd=%h exp tos=%h nos=%h c=%b v=%b pu=%b po=%b pd=%h",
               r, act, op, tos_o, nos_o, carry_o, ovfl_o, push_o, pop_o, pdata_o,
               e_tos, e_nos, e_c, e_v, e_push, e_pop, e_pd);
    end
  endtask

  task automatic step(logic v, logic [2:0] o, logic [1:0] a,
                      logic [W-1:0] t, logic [W-1:0] n, logic [W-1:0] b, logic c);
    @(negedge clk);
    valid = v; op = o; act = a; tos = t; nos = n; below = b; cin = c;
    model(v, o, a, t, n, b, c);
    @(negedge clk);
    check(tag(v, a, o));
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] corner [4];
    void'($urandom(32'h5A17));
    corner[0] = 0; corner[1] = '1; corner[2] = 16'h8000; corner[3] = 16'h7FFF;
    valid = 0; op = 0; act = 0; tos = 0; nos = 0; below = 0; cin = 0;
    #9;
    check("R1");
    @(negedge clk) rst_ni = 1;
    // directed
    step(1, 0, 1, 16'h0001, 16'h7FFF, 16'h1234, 0);  // ADD signed overflow, R4
    step(1, 2, 2, 16'h0001, 16'h0000, 16'h0, 0);     // SUB borrow, R3
    step(1, 3, 1, 16'h0001, 16'h0001, 16'h55, 0);    // SSUB no borrow
    step(1, 1, 2, 16'hFFFF, 16'h0000, 16'h0, 1);     // ADC wrap
    step(0, 5, 2, 16'h1111, 16'h2222, 16'h3, 1);     // idle, R12
    step(1, 6, 3, 16'h0000, 16'h4444, 16'h0, 1);     // ZEQU true, R10
    step(1, 4, 3, 16'h0001, 16'h4444, 16'h0, 1);     // ROR, R9
    step(1, 2, 3, 16'h8001, 16'h0, 16'h0, 0);        // ASR, R8
    step(1, 7, 0, 16'hAAAA, 16'h5555, 16'h0, 1);     // swap, R11
    foreach (corner[i]) for (int j = 0; j < 4; j++)
      for (int o = 0; o < 4; o++)
        step(1, 3'(o), 2'($urandom_range(1, 2)), corner[i], corner[j], 16'($urandom), 1'($urandom));
    for (int k = 0; k < 600; k++)
      step(($urandom_range(0, 7) != 0), 3'($urandom), 2'($urandom),
           16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule